// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the digital feedback path of a fractional-N frequency synthesizer. It runs on the oscillator-rate clock and produces one feedback pulse per division cycle for the phase detector. The cycle length is built the pulse-swallow way around a 16/17 dual-modulus prescaler. A program count P and a swallow count S give N = 16·P + S. The prescaler divides by 17 for the first S of its periods and by 16 for the remaining P − S.

A first-order phase accumulator of FRAC_W bits adds the fractional word once per division cycle. Its carry extends that one cycle by a single input period, so over time the average ratio is the integer word plus frac_word / 2^FRAC_W. With a 40 MHz reference and an oscillator at 1290 MHz, an integer word of 32 and a fractional word of 1 (FRAC_W = 2) give the 32.25 average needed. A separate toggle stage halves the oscillator clock into a 50% duty output, which gives 645 MHz in that case. Both words are sampled only when a division cycle starts. A controller can therefore rewrite them on every cycle, for example to sweep the frequency for spread-spectrum clocking, and no period is ever cut short.

Top module: `fracn_fb_div`

## Requirements
- R1: While rst_n is low, fb_clk, mod_ctl and out_clk are all 0, and the accumulator and all counters are cleared.
- R2: Count as edge 1 the first rising clk_vco edge with rst_n high. fb_clk goes high after edge N, where N is the integer word applied at release. It stays high for exactly one clk_vco period.
- R3: With a fractional word of 0, fb_clk pulses every N clk_vco cycles. The integer word must be legal: P = N div 16 ≥ 1 and S = N mod 16 ≤ P, both for N and for N+1.
- R4: In every division cycle after the first, mod_ctl is high for exactly 17·S clk_vco cycles, counted from the cycle that starts with the fb_clk pulse. S is the low 4 bits of that cycle's ratio.
- R5: Number the division cycles i = 1, 2, … from reset. Cycle i lasts N+1 cycles when floor(i·F/2^FRAC_W) > floor((i−1)·F/2^FRAC_W), and N cycles otherwise. F is the fractional word. So the first 2^FRAC_W cycles total 2^FRAC_W·N + F.
- R6: int_word and frac_word are sampled only at the start of a division cycle. A change in mid-cycle leaves the current period unchanged and takes effect in the next period.
- R7: out_clk toggles on every clk_vco rising edge after release. It is 1 after edge 1, so its duty cycle is 50%.
- R8: The carry adds to the full integer word without wrapping. An integer word of 2^INT_W − 1 with a carry gives a period of 2^INT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate input clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_vco |
| int_word | input | INT_W | Integer division ratio N = 16·P + S |
| frac_word | input | FRAC_W | Fractional step added to the accumulator each cycle |
| fb_clk | output | 1 | One-period feedback pulse at the end of each division cycle |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by 17 |
| out_clk | output | 1 | Oscillator clock divided by 2, 50% duty |

## Verification
The tight case is when the swallow count runs out on the last prescaler period of a cycle, that is S = P, as with ratios 34 or 51. The decrement of the swallow count and the reload for the next cycle then fall on the same edge. The bench drives such ratios and checks that mod_ctl stays high for exactly 17·S cycles of each window and that no period grows or shrinks. A second coincidence is an accumulator carry on the same boundary as a new word. The bench checks this with a mid-cycle word change and with the all-ones integer word, and the resulting periods must match the R5 sequence computed from the words.

// File: rtl/fracn_fb_div.sv
module fracn_fb_div #(
  parameter int INT_W    = 9,
  parameter int FRAC_W   = 2,
  parameter int PRE_LOG2 = 4
) (
  input  logic              clk_vco,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_word,
  input  logic [FRAC_W-1:0] frac_word,
  output logic              fb_clk,
  output logic              mod_ctl,
  output logic              out_clk
);
  localparam int N_W = INT_W + 1;
  localparam int P_W = N_W - PRE_LOG2;
  localparam int C_W = PRE_LOG2 + 1;
  localparam logic [C_W-1:0] LAST_LO = C_W'((1 << PRE_LOG2) - 1);
  localparam logic [C_W-1:0] LAST_HI = C_W'(1 << PRE_LOG2);

  logic                run;
  logic [C_W-1:0]      pre_cnt;
  logic [P_W-1:0]      p_left;
  logic [PRE_LOG2-1:0] s_left;
  logic [FRAC_W-1:0]   acc;
  logic                fb_q, out_q;

  logic [FRAC_W:0] acc_sum;
  logic [N_W-1:0]  n_next;
  assign acc_sum = {1'b0, acc} + {1'b0, frac_word};
  assign n_next  = {1'b0, int_word} + N_W'(acc_sum[FRAC_W]);

  logic swallow, pre_last, cyc_end, load;
  assign swallow  = (s_left != '0);
  assign pre_last = run && (pre_cnt == (swallow ? LAST_HI : LAST_LO));
  assign cyc_end  = pre_last && (p_left == P_W'(1));
  assign load     = !run || cyc_end;

  always_ff @(posedge clk_vco) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pre_cnt <= '0;
      p_left  <= '0;
      s_left  <= '0;
      acc     <= '0;
      fb_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      out_q <= ~out_q;
      fb_q  <= cyc_end;
      if (load) begin
        run     <= 1'b1;
        acc     <= acc_sum[FRAC_W-1:0];
        p_left  <= n_next[N_W-1:PRE_LOG2];
        s_left  <= n_next[PRE_LOG2-1:0];
        pre_cnt <= run ? '0 : C_W'(1);
      end else if (pre_last) begin
        pre_cnt <= '0;
        p_left  <= p_left - P_W'(1);
        if (swallow) s_left <= s_left - PRE_LOG2'(1);
      end else begin
        pre_cnt <= pre_cnt + C_W'(1);
      end
    end
  end

  assign fb_clk  = fb_q;
  assign mod_ctl = swallow;
  assign out_clk = out_q;

  p_fb_single_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_clk |=> !fb_clk);

  p_legal_ratio_r3: assert property (@(posedge clk_vco) disable iff (!rst_n)
    load |-> (n_next[N_W-1:PRE_LOG2] != '0) &&
             (P_W'(n_next[PRE_LOG2-1:0]) <= n_next[N_W-1:PRE_LOG2]));

  p_swallow_drop_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
    $fell(mod_ctl) |-> $past(pre_last));

  p_out_toggle_r7: assert property (@(posedge clk_vco) disable iff (!rst_n)
    $past(rst_n) |-> (out_clk != $past(out_clk)));
endmodule

// File: tb/fracn_fb_div_tb.sv
module fracn_fb_div_tb;
  localparam int INT_W = 9;
  localparam int FRAC_W = 2;
  localparam int NROW = 8;
  localparam int TBL [NROW][3] = '{
    '{32, 1, 129}, '{32, 0, 128}, '{33, 0, 132}, '{33, 2, 134},
    '{50, 3, 203}, '{64, 1, 257}, '{34, 0, 136}, '{51, 0, 204}};

  logic clk_vco = 1'b0;
  logic rst_n = 1'b0;
  logic [INT_W-1:0] int_word = '0;
  logic [FRAC_W-1:0] frac_word = '0;
  logic fb_clk, mod_ctl, out_clk;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_vco = ~clk_vco;

  fracn_fb_div #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_LOG2(4)) u_dut (
    .clk_vco(clk_vco), .rst_n(rst_n), .int_word(int_word),
    .frac_word(frac_word), .fb_clk(fb_clk), .mod_ctl(mod_ctl), .out_clk(out_clk));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_n(input int iw, input int f, input int i);
    int m = 1 << FRAC_W;
    return iw + ((((i * f) / m) > (((i - 1) * f) / m)) ? 1 : 0);
  endfunction

  task automatic do_reset(input int iw, input int f);
    @(negedge clk_vco);
    rst_n = 1'b0;
    int_word = INT_W'(iw);
    frac_word = FRAC_W'(f);
    repeat (3) @(negedge clk_vco);
  endtask

  task automatic run_row(input int iw, input int f, input int exp_sum);
    int j = 0, pulses = 0, last = 0, modc = 0, toggles_bad = 0, wide = 0;
    bit prev_fb = 0;
    do_reset(iw, f);
    rst_n = 1'b1;
    while (pulses < 4 && j < 3000) begin
      @(negedge clk_vco);
      j++;
      if (out_clk != j[0]) toggles_bad++;
      if (fb_clk) begin
        if (prev_fb) wide++;
        pulses++;
        if (pulses == 1) check(j == iw, "R2 first pulse", j, iw);
        else begin
          int n = model_n(iw, f, pulses);
          check(j - last == n, "R5 period", j - last, n);
          check(modc == 17 * (n % 16), "R4 mod_ctl high count", modc, 17 * (n % 16));
        end
        last = j;
        modc = 0;
      end
      if (mod_ctl) modc++;
      prev_fb = fb_clk;
    end
    check(j == exp_sum, "R5 sum of first four periods", j, exp_sum);
    check(wide == 0, "R2 pulse width", wide, 0);
    check(toggles_bad == 0, "R7 out_clk toggle", toggles_bad, 0);
  endtask

  task automatic pulse_times(input int iw, input int f, input int chg_at, input int new_iw,
                             output int t1, output int t2, output int t3);
    int j = 0, pulses = 0;
    t1 = 0; t2 = 0; t3 = 0;
    do_reset(iw, f);
    rst_n = 1'b1;
    while (pulses < 3 && j < 4000) begin
      @(negedge clk_vco);
      j++;
      if (fb_clk) begin
        pulses++;
        if (pulses == 1) t1 = j; else if (pulses == 2) t2 = j; else t3 = j;
      end
      if (j == chg_at) int_word = INT_W'(new_iw);
    end
  endtask

  initial begin
    int t1, t2, t3;
    do_reset(32, 1);
    check(fb_clk == 0, "R1 fb_clk in reset", fb_clk, 0);
    check(mod_ctl == 0, "R1 mod_ctl in reset", mod_ctl, 0);
    check(out_clk == 0, "R1 out_clk in reset", out_clk, 0);

    for (int r = 0; r < NROW; r++) run_row(TBL[r][0], TBL[r][1], TBL[r][2]);

    // R6: word change in mid-cycle applies to the following period only
    pulse_times(32, 0, 40, 48, t1, t2, t3);
    check(t1 == 32, "R6 first period", t1, 32);
    check(t2 == 64, "R6 period unchanged by mid-cycle write", t2, 64);
    check(t3 == 112, "R6 new word in next period", t3, 112);

    // R8: all-ones integer word plus carry does not wrap
    pulse_times(511, 3, 0, 511, t1, t2, t3);
    check(t1 == 511, "R8 first period", t1, 511);
    check(t2 == 1023, "R8 carry period 512", t2, 1023);
    check(t3 == 1535, "R8 second carry period 512", t3, 1535);

    // R3: integer-only ratio repeats
    pulse_times(48, 0, 0, 48, t1, t2, t3);
    check(t3 - t2 == 48 && t2 - t1 == 48, "R3 steady integer period", t3 - t2, 48);

    // R1: reset asserted mid-run clears outputs
    repeat (5) @(negedge clk_vco);
    rst_n = 1'b0;
    @(negedge clk_vco);
    check(fb_clk == 0 && mod_ctl == 0 && out_clk == 0, "R1 reset mid-run",
          {fb_clk, mod_ctl, out_clk}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_vco);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule